// File: doc/BRIEF.md
# Enable-Gated Bit-Slice ALU

This block is a purely combinational arithmetic and logic unit assembled from identical one-bit slices. Each slice contains a carry stage and a two-stage sum path. Both stages of the sum path are the same gated exclusive-OR primitive, a four-NAND network with three enable inputs. A one-bit carry chain ripples from the least significant slice up to the most significant one. The logic functions are not chosen by a result multiplexer. They come from switching individual NAND inputs of the sum path on and off.

A small decoder turns a 3-bit operation code into the five steering signals every slice shares: the cross-term enable, the A-side enable, the B-side enable, the carry enable and the B invert. Eight operations are available: zero, OR, B-and-not-A, A-and-not-B, XOR, add with carry-in, AND, and subtract with borrow (A plus the complement of B plus carry-in). The carry out of the top slice is always driven. Under a logic operation it still follows the chain and does not float.

Top module: `bit_slice_alu`

## Requirements
- R1: With op = 3'b000 the result is all zeros for any operands and carry-in.
- R2: With op = 3'b001 the result is the bitwise OR of A and B.
- R3: With op = 3'b010 the result is B AND NOT A, bit by bit.
- R4: With op = 3'b011 the result is A AND NOT B, bit by bit.
- R5: With op = 3'b100 the result is the bitwise XOR of A and B.
- R6: With op = 3'b101 the result is the low WIDTH bits of A + B + carry_in.
- R7: With op = 3'b110 the result is the bitwise AND of A and B.
- R8: With op = 3'b111 the result is the low WIDTH bits of A + (NOT B) + carry_in, which equals A − B − 1 + carry_in.
- R9: For every opcode, carry_out is bit WIDTH of A + B' + carry_in. Here B' is NOT B for op 3'b110 and 3'b111, and B for every other opcode. The carry chain runs during logic operations as well.
- R10: Only add and subtract enable the carry into the sum. Every logic opcode, including zero, gives a result that does not depend on carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 3 | Operation code, decoded to the five slice controls |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| carry_in | input | 1 | Carry into slice 0 |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The result word and the carry out are produced together on every operation. During a logic operation the carry chain is still active, so a full-width carry ripple can happen at the same time as a bitwise result. The bench provokes this case with operand pairs such as all-ones with one, and with a carry-in of one, under the OR, AND and XOR opcodes. In the same cycle it compares the result against the bitwise reference and the carry against the widened arithmetic sum. Each logic opcode also repeats its operands with the carry-in flipped, so a carry that leaks into the sum shows up as a mismatch.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ZERO = 3'd0,
        OP_OR   = 3'd1,
        OP_BNA  = 3'd2,
        OP_ANB  = 3'd3,
        OP_XOR  = 3'd4,
        OP_ADD  = 3'd5,
        OP_AND  = 3'd6,
        OP_SUB  = 3'd7
    } op_e;

    // Steering shared by every slice
    typedef struct packed {
        logic xen;   // cross-term enable of the first gate
        logic aen;   // A-side enable of the first gate
        logic ben;   // B-side enable of the first gate
        logic cen;   // carry participates in the sum
        logic binv;  // B operand is complemented
    } slice_ctrl_t;

    function automatic slice_ctrl_t decode_op(input op_e op);
        slice_ctrl_t c;
        case (op)
            OP_ZERO: c = '{xen:1'b0, aen:1'b0, ben:1'b0, cen:1'b0, binv:1'b0};
            OP_OR:   c = '{xen:1'b0, aen:1'b1, ben:1'b1, cen:1'b0, binv:1'b0};
            OP_BNA:  c = '{xen:1'b1, aen:1'b0, ben:1'b1, cen:1'b0, binv:1'b0};
            OP_ANB:  c = '{xen:1'b1, aen:1'b1, ben:1'b0, cen:1'b0, binv:1'b0};
            OP_XOR:  c = '{xen:1'b1, aen:1'b1, ben:1'b1, cen:1'b0, binv:1'b0};
            OP_ADD:  c = '{xen:1'b1, aen:1'b1, ben:1'b1, cen:1'b1, binv:1'b0};
            OP_AND:  c = '{xen:1'b1, aen:1'b1, ben:1'b0, cen:1'b0, binv:1'b1};
            OP_SUB:  c = '{xen:1'b1, aen:1'b1, ben:1'b1, cen:1'b1, binv:1'b1};
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsalu_gate.sv
// Four-NAND exclusive-OR with an enable on each of its three inner gates.
module bsalu_gate (
    input  logic xen,
    input  logic aen,
    input  logic ben,
    input  logic in_a,
    input  logic in_b,
    output logic f
);
    logic cross_n;
    logic side_a_n;
    logic side_b_n;

    always_comb begin
        cross_n  = ~(xen & in_a & in_b);
        side_a_n = ~(aen & in_a & cross_n);
        side_b_n = ~(ben & in_b & cross_n);
        f        = ~(side_a_n & side_b_n);
    end

    // With every enable low the gate output must be quiet
    always_comb begin
        if (!$isunknown({xen, aen, ben, in_a, in_b})) begin
            if (!xen && !aen && !ben) begin
                assert_gate_quiet_R1: assert (f == 1'b0)
                    else $error("gate output high with all enables low");
            end
        end
    end
endmodule

// File: rtl/bsalu_decode.sv
module bsalu_decode
    import bsalu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output slice_ctrl_t     ctrl
);
    always_comb ctrl = decode_op(op_e'(op));

    // The carry may enter the sum only on the arithmetic opcodes, which
    // also need the full exclusive-OR in the first gate
    always_comb begin
        if (!$isunknown(op)) begin
            assert_cen_arith_R10: assert (ctrl.cen == (op == OP_ADD || op == OP_SUB))
                else $error("carry enable on opcode %0d", op);
            if (ctrl.cen) begin
                assert_cen_full_xor_R6: assert (ctrl.xen && ctrl.aen && ctrl.ben)
                    else $error("carry enabled without full xor");
            end
        end
    end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
    import bsalu_pkg::*;
(
    input  slice_ctrl_t ctrl,
    input  logic        a,
    input  logic        b,
    input  logic        cin,
    output logic        f,
    output logic        cout
);
    logic b_eff;
    logic stage1;

    always_comb b_eff = b ^ ctrl.binv;

    bsalu_gate u_first (
        .xen  (ctrl.xen),
        .aen  (ctrl.aen),
        .ben  (ctrl.ben),
        .in_a (a),
        .in_b (b_eff),
        .f    (stage1)
    );

    // A side always on; carry gated by the carry enable
    bsalu_gate u_second (
        .xen  (ctrl.cen),
        .aen  (1'b1),
        .ben  (ctrl.cen),
        .in_a (stage1),
        .in_b (cin),
        .f    (f)
    );

    always_comb cout = (a & b_eff) | (a & cin) | (b_eff & cin);
endmodule

// File: rtl/bit_slice_alu.sv
module bit_slice_alu
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN_W = WIDTH + 1;

    slice_ctrl_t        ctrl;
    logic [CHAIN_W-1:0] chain;

    bsalu_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    assign chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bsalu_slice u_slice (
            .ctrl (ctrl),
            .a    (opa[i]),
            .b    (opb[i]),
            .cin  (chain[i]),
            .f    (result[i]),
            .cout (chain[i+1])
        );
    end

    assign carry_out = chain[WIDTH];

    // Port-level checks against plain word arithmetic
    logic [WIDTH-1:0] b_word;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_word   = (op == OP_AND || op == OP_SUB) ? ~opb : opb;
        wide_sum = {1'b0, opa} + {1'b0, b_word} + {{WIDTH{1'b0}}, carry_in};
    end

    always_comb begin
        if (!$isunknown({op, opa, opb, carry_in})) begin
            assert_carry_out_R9: assert (carry_out == wide_sum[WIDTH])
                else $error("carry_out mismatch");
            case (op_e'(op))
                OP_ZERO: assert_zero_R1: assert (result == '0)
                    else $error("zero op gave %h", result);
                OP_OR:   assert_or_R2: assert (result == (opa | opb))
                    else $error("or mismatch");
                OP_BNA:  assert_bna_R3: assert (result == (opb & ~opa))
                    else $error("b-and-not-a mismatch");
                OP_ANB:  assert_anb_R4: assert (result == (opa & ~opb))
                    else $error("a-and-not-b mismatch");
                OP_XOR:  assert_xor_R5: assert (result == (opa ^ opb))
                    else $error("xor mismatch");
                OP_ADD:  assert_add_R6: assert (result == wide_sum[WIDTH-1:0])
                    else $error("add mismatch");
                OP_AND:  assert_and_R7: assert (result == (opa & opb))
                    else $error("and mismatch");
                OP_SUB:  assert_sub_R8: assert (result == wide_sum[WIDTH-1:0])
                    else $error("sub mismatch");
                default: ;
            endcase
        end
    end
endmodule

// File: tb/bit_slice_alu_tb.sv
module bit_slice_alu_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bit_slice_alu #(.WIDTH(W)) u_dut (
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Behavioural reference: {carry, result}
    function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic c);
        longint unsigned s;
        logic [W-1:0]    r;
        logic [W-1:0]    yy;
        yy = (o == 3'd6 || o == 3'd7) ? ~y : y;
        s  = longint'(x) + longint'(yy) + longint'(c);
        case (o)
            3'd0: r = '0;
            3'd1: r = x | y;
            3'd2: r = y & ~x;
            3'd3: r = x & ~y;
            3'd4: r = x ^ y;
            3'd5: r = s[W-1:0];
            3'd6: r = x & y;
            default: r = s[W-1:0];
        endcase
        return {s[W], r};
    endfunction

    task automatic apply(input logic [2:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic c);
        logic [W:0] exp;
        @(posedge clk);
        op = o; opa = x; opb = y; carry_in = c;
        exp = model(o, x, y, c);
        @(negedge clk);
        checks++;
        if (result !== exp[W-1:0]) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%0d result actual=%h expected=%h",
                     req_of(o), o, x, y, c, result, exp[W-1:0]);
        end
        checks++;
        if (carry_out !== exp[W]) begin
            errors++;
            $display("FAIL R9 op=%0d a=%h b=%h cin=%0d carry actual=%0d expected=%0d",
                     o, x, y, c, carry_out, exp[W]);
        end
    endtask

    // R10: logic result must not move when only carry_in changes
    task automatic cin_blind(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r0;
        @(posedge clk);
        op = o; opa = x; opb = y; carry_in = 1'b0;
        @(negedge clk);
        r0 = result;
        @(posedge clk);
        carry_in = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== r0) begin
            errors++;
            $display("FAIL R10 op=%0d result actual=%h expected=%h", o, result, r0);
        end
    endtask

    initial begin
        logic [W-1:0] corners [8];
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = 16'h0001;
        corners[3] = 16'h8000;
        corners[4] = 16'h7FFF;
        corners[5] = 16'hAAAA;
        corners[6] = 16'h5555;
        corners[7] = 16'h00FF;

        repeat (3) @(posedge clk);
        // Reset state: idle inputs give a zero word, no carry (R1, R9)
        @(negedge clk);
        checks++;
        if (result !== '0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual=%h/%0d expected=0000/0", result, carry_out);
        end
        rst = 1'b0;

        // Corner operand sweep over every opcode and carry-in
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int c = 0; c < 2; c++)
                        apply(3'(o), corners[i], corners[j], 1'(c));

        // Full ripple during logic ops: carry and result judged together (R9)
        for (int o = 0; o < 5; o++) apply(3'(o), '1, 16'h0001, 1'b1);
        apply(3'd6, '1, '0, 1'b1);

        // Carry-in blindness of every logic opcode (R10)
        for (int o = 0; o < 5; o++) cin_blind(3'(o), 16'h1234, 16'hF0F0);
        cin_blind(3'd6, 16'hFFFF, 16'h5A5A);

        // Random operands
        for (int k = 0; k < 2000; k++)
            apply(3'($urandom_range(0, 7)), W'($urandom), W'($urandom), 1'($urandom_range(0, 1)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule